// File: doc/BRIEF.md
# Page-Mode Parallel Flash Read Controller

This block is a synchronous host-side engine that fetches 16-bit words from an asynchronous parallel NOR flash that supports page-mode reads. On the system side a request carries a 23-bit word address. The block accepts it when `req_ready` is high. Some cycles later it returns the word with a single-cycle `rsp_valid` strobe. On the flash side it drives the chip-enable, output-enable, write-enable and reset pins and the address bus, and it samples the data bus.

The flash answers slowly to a random address and faster to a word inside an 8-word page that is already open. The controller records which page is open. The low three address bits pick the word, and the upper twenty bits name the page. It waits the short in-page count only when chip enable has stayed asserted and the page matches. Every other read gets the long initial count.

Between reads, chip enable stays low with output enable high, so the bus is not driven. After a parameterised stretch with no request, the controller drops to standby: it releases chip enable and forgets the page. A synchronous reset holds the flash reset pin low for a parameterised number of cycles. Read-array mode is the flash's power-up state, so no command is issued before the first read.

Top module: `pflash_rd_ctrl`

## Requirements
- R1: While `rst` is high, and for `RST_CYC` (default 4) clock edges after it falls, `fl_rst_n` is 0, `fl_ce_n` and `fl_oe_n` are 1, and `req_ready` is 0. On the `RST_CYC`-th edge the controller becomes ready and `fl_rst_n` returns to 1.
- R2: During an access, `fl_ce_n`=0, `fl_oe_n`=0, `fl_we_n`=1, `fl_rst_n`=1, and `fl_addr` equals the accepted address. `fl_oe_n` is never 0 while `fl_ce_n` is 1.
- R3: An initial access returns `rsp_valid` exactly `T_INIT` (default 8) clock edges after the accepting edge.
- R4: If `req_addr[22:3]` equals the open page and chip enable has been held since that page was opened, the response comes `T_PAGE` (default 3) edges after acceptance.
- R5: A request whose bits [22:3] differ from the open page takes `T_INIT` and becomes the new open page.
- R6: After `IDLE_LIMIT` (default 16) consecutive idle edges with no accepted request, `fl_ce_n` goes to 1 and the page is forgotten. The next read takes `T_INIT`, even if it targets the same page.
- R7: Between accesses with chip enable held, `fl_oe_n` is 1 (output disable). `rsp_data` is the bus value sampled on the final wait edge, while `fl_oe_n` is 0.
- R8: `req_ready` is 0 from the accepting edge until the response edge. `rsp_valid` is high for exactly one cycle.
- R9: The first read after reset needs no command and is an initial access, whatever page was open before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 23 | Word address of the request |
| req_ready | output | 1 | Controller can accept a request |
| rsp_valid | output | 1 | One-cycle strobe with returned data |
| rsp_data | output | 16 | Word read from flash |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, held high |
| fl_rst_n | output | 1 | Flash reset, active low |
| fl_addr | output | 23 | Flash word address |
| fl_dq_in | input | 16 | Flash data bus |

## Verification
A stale page tag or a page-valid flag that is never cleared shows up at the very next response. That response arrives `T_PAGE` edges after acceptance where `T_INIT` was due, or the reverse, so the bench checks the exact response cycle of every read against its own page model. A wrong idle counter shows as `fl_ce_n` still low (or already high) right after a gap just longer (or shorter) than `IDLE_LIMIT`. A capture taken with output enable high returns the bench's idle-bus pattern in place of the addressed word on that same strobe.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  typedef enum logic [1:0] {
    S_RST  = 2'd0,
    S_IDLE = 2'd1,
    S_WAIT = 2'd2
  } pfr_state_e;

  // wait length chosen for a new access
  function automatic int unsigned pick_wait(input logic in_page,
                                            input int unsigned t_init,
                                            input int unsigned t_page);
    return in_page ? t_page : t_init;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/pfr_wait_cnt.sv
module pfr_wait_cnt #(
  parameter int unsigned CW      = 4,
  parameter int unsigned RST_VAL = 4
) (
  input  logic          clk,
  input  logic          rst_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst_i)                        cnt_q <= CW'(RST_VAL);
    else if (load_i)                  cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == CW'(1));

  // a countdown is only stepped while something remains to count (R3)
  p_dec_nonzero_r3: assert property (@(posedge clk) disable iff (rst_i)
    dec_i |-> cnt_q != '0);
endmodule

// File: rtl/pfr_page_track.sv
module pfr_page_track #(
  parameter int unsigned TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst_i,
  input  logic             open_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             clear_i,
  output logic             hit_o,
  output logic             valid_o
);
  logic [TAG_W-1:0] tag_q;
  logic             valid_q;

  always_ff @(posedge clk) begin
    if (rst_i) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else if (open_i) begin
      valid_q <= 1'b1;
      tag_q   <= tag_i;
    end else if (clear_i) begin
      valid_q <= 1'b0;
    end
  end

  assign hit_o   = valid_q && (tag_q == tag_i);
  assign valid_o = valid_q;

  // a clear without a concurrent open leaves no page behind (R6)
  p_clear_forgets_r6: assert property (@(posedge clk) disable iff (rst_i)
    clear_i && !open_i |=> !valid_o);
endmodule

// File: rtl/pfr_idle_timer.sv
module pfr_idle_timer #(
  parameter int unsigned IDLE_LIMIT = 16
) (
  input  logic clk,
  input  logic rst_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned IW = (IDLE_LIMIT < 2) ? 1 : $clog2(IDLE_LIMIT + 1);

  logic [IW-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == IW'(IDLE_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst_i || !run_i || expire_o) cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end

  // the count never passes the limit (R6)
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst_i)
    cnt_q < IW'(IDLE_LIMIT));
endmodule

// File: rtl/pflash_rd_ctrl.sv
module pflash_rd_ctrl
  import pfr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 23,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned WORD_BITS  = 3,
  parameter int unsigned T_INIT     = 8,
  parameter int unsigned T_PAGE     = 3,
  parameter int unsigned IDLE_LIMIT = 16,
  parameter int unsigned RST_CYC    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n,
  output logic              fl_rst_n,
  output logic [ADDR_W-1:0] fl_addr,
  input  logic [DATA_W-1:0] fl_dq_in
);
  localparam int unsigned TAG_W = ADDR_W - WORD_BITS;
  localparam int unsigned MAXW  = max3(T_INIT, T_PAGE, RST_CYC);
  localparam int unsigned CW    = $clog2(MAXW + 1);

  pfr_state_e        state_q;
  logic              ce_act_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;

  // named internal events
  logic          accept_ev;
  logic          capture_ev;
  logic          idle_expire;
  logic          page_hit;
  logic          page_valid;
  logic          cnt_last;
  logic          cnt_dec;
  logic [CW-1:0] cnt_val;
  logic [CW-1:0] wait_len;

  assign accept_ev  = (state_q == S_IDLE) && req_valid;
  assign capture_ev = (state_q == S_WAIT) && cnt_last;
  assign cnt_dec    = (state_q == S_RST) || (state_q == S_WAIT);
  assign wait_len   = CW'(pick_wait(page_hit && ce_act_q, T_INIT, T_PAGE));

  pfr_wait_cnt #(.CW(CW), .RST_VAL(RST_CYC)) u_cnt (
    .clk        (clk),
    .rst_i      (rst),
    .load_i     (accept_ev),
    .load_val_i (wait_len),
    .dec_i      (cnt_dec),
    .cnt_o      (cnt_val),
    .last_o     (cnt_last)
  );

  pfr_page_track #(.TAG_W(TAG_W)) u_page (
    .clk     (clk),
    .rst_i   (rst),
    .open_i  (accept_ev),
    .tag_i   (req_addr[ADDR_W-1:WORD_BITS]),
    .clear_i (idle_expire),
    .hit_o   (page_hit),
    .valid_o (page_valid)
  );

  pfr_idle_timer #(.IDLE_LIMIT(IDLE_LIMIT)) u_idle (
    .clk      (clk),
    .rst_i    (rst),
    .run_i    ((state_q == S_IDLE) && ce_act_q && !accept_ev),
    .expire_o (idle_expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_RST;
      ce_act_q    <= 1'b0;
      addr_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        S_RST: begin
          if (cnt_last) state_q <= S_IDLE;
        end
        S_IDLE: begin
          if (accept_ev) begin
            addr_q   <= req_addr;
            ce_act_q <= 1'b1;
            state_q  <= S_WAIT;
          end else if (idle_expire) begin
            ce_act_q <= 1'b0;
          end
        end
        S_WAIT: begin
          if (cnt_last) begin
            rsp_data_q  <= fl_dq_in;
            rsp_valid_q <= 1'b1;
            state_q     <= S_IDLE;
          end
        end
        default: state_q <= S_RST;
      endcase
    end
  end

  assign req_ready = (state_q == S_IDLE);
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign fl_ce_n   = !ce_act_q;
  assign fl_oe_n   = (state_q != S_WAIT);
  assign fl_we_n   = 1'b1;
  assign fl_rst_n  = (state_q != S_RST);
  assign fl_addr   = addr_q;

  p_rst_pin_r1: assert property (@(posedge clk) disable iff (rst)
    !fl_rst_n |-> !req_ready && fl_ce_n && fl_oe_n);

  p_oe_needs_ce_r2: assert property (@(posedge clk) disable iff (rst)
    !fl_oe_n |-> !fl_ce_n && fl_rst_n && fl_we_n);

  p_release_r6: assert property (@(posedge clk) disable iff (rst)
    idle_expire |=> fl_ce_n && !page_valid);

  p_sample_enabled_r7: assert property (@(posedge clk) disable iff (rst)
    capture_ev |-> !fl_oe_n && !fl_ce_n && cnt_val == CW'(1));

  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
    accept_ev |=> !req_ready && !rsp_valid);

  p_rsp_single_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/pflash_rd_ctrl_tb.sv
module pflash_rd_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int T_INIT     = 8;
  localparam int T_PAGE     = 3;
  localparam int IDLE_LIMIT = 16;
  localparam int RST_CYC    = 4;
  localparam logic [15:0] IDLE_BUS = 16'hBAD0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [22:0] req_addr = '0;
  logic        req_ready, rsp_valid, fl_ce_n, fl_oe_n, fl_we_n, fl_rst_n;
  logic [15:0] rsp_data, fl_dq;
  logic [22:0] fl_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  pflash_rd_ctrl dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
    .fl_rst_n(fl_rst_n), .fl_addr(fl_addr), .fl_dq_in(fl_dq)
  );

  function automatic logic [15:0] word_of(input logic [22:0] a);
    return a[15:0] ^ {a[22:16], 9'h0A5};
  endfunction

  // flash model: drives the word only when read-enabled
  assign fl_dq = (!fl_ce_n && !fl_oe_n && fl_rst_n) ? word_of(fl_addr) : IDLE_BUS;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int last_rsp_cyc = 0;
  logic        page_open = 1'b0;
  logic [19:0] page_tag = '0;
  logic        prev_rv = 1'b0;

  logic [15:0] exp_data_q[$];
  int          exp_cyc_q[$];
  string       exp_req_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: pops the scoreboard on every response
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_rv && rsp_valid) chk("R8 single-cycle strobe", 1'b0, 1, 0);
      if (rsp_valid) begin
        if (exp_data_q.size() == 0) begin
          chk("R8 unexpected response", 1'b0, rsp_data, 0);
        end else begin
          automatic logic [15:0] ed = exp_data_q.pop_front();
          automatic int          ec = exp_cyc_q.pop_front();
          automatic string       er = exp_req_q.pop_front();
          chk({er, " latency"}, cyc == ec, cyc, ec);
          chk("R7 data sampled with bus enabled", rsp_data == ed, rsp_data, ed);
        end
        last_rsp_cyc = cyc;
      end
    end
    prev_rv = rsp_valid;
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset pins", !fl_rst_n && fl_ce_n && fl_oe_n && !req_ready && !rsp_valid,
        {fl_rst_n, fl_ce_n, fl_oe_n, req_ready}, 4'b0110);
    rst = 1'b0;
    for (int k = 1; k <= RST_CYC; k++) begin
      @(negedge clk);
      if (k < RST_CYC) chk("R1 reset hold", !fl_rst_n && !req_ready, fl_rst_n, 0);
      else chk("R1 reset release", fl_rst_n && req_ready && fl_ce_n, {fl_rst_n, req_ready}, 2'b11);
    end
    page_open = 1'b0;
  endtask

  task automatic read(input logic [22:0] a, input int gap);
    int acc;
    logic fast;
    repeat (gap) @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    acc  = cyc + 1;
    fast = page_open && (page_tag == a[22:3]) && (acc - last_rsp_cyc - 1 < IDLE_LIMIT);
    exp_data_q.push_back(word_of(a));
    exp_cyc_q.push_back(acc + (fast ? T_PAGE : T_INIT));
    exp_req_q.push_back(fast ? "R4 in-page" : "R3/R5 initial");
    page_open = 1'b1;
    page_tag  = a[22:3];
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 read pins", !fl_ce_n && !fl_oe_n && fl_we_n && fl_rst_n, {fl_ce_n, fl_oe_n, fl_we_n, fl_rst_n}, 4'b0011);
    chk("R2 address", fl_addr == a, fl_addr, a);
    chk("R8 busy", !req_ready, req_ready, 0);
    while (exp_data_q.size() != 0) @(negedge clk);
    chk("R7 output disable after read", fl_oe_n, fl_oe_n, 1);
  endtask

  always @(posedge clk) begin
    if (cyc == 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    read(23'h000010, 0);                 // R9 first read after reset: initial
    read(23'h000013, 0);                 // R4 same page
    read(23'h000017, 1);                 // R4 last word of page
    read(23'h000018, 0);                 // R5 page change
    repeat (2) @(negedge clk);
    chk("R7 CE held, OE high", !fl_ce_n && fl_oe_n, {fl_ce_n, fl_oe_n}, 2'b01);
    read(23'h00001A, 0);                 // R4 after short gap
    repeat (IDLE_LIMIT + 3) @(negedge clk);
    chk("R6 standby releases CE", fl_ce_n, fl_ce_n, 1);
    read(23'h00001B, 0);                 // R6 same page, full wait
    read(23'h00001C, IDLE_LIMIT - 4);    // R4 gap below limit
    read(23'h7FFFFF, 0);                 // R5 top page
    read(23'h7FFFF8, 0);                 // R4
    do_reset();
    read(23'h7FFFF9, 0);                 // R9 same page, initial after reset
    read(23'h7FFFFA, 0);                 // R4
    repeat (3) @(negedge clk);
    chk("R8 no stray responses", exp_data_q.size() == 0, exp_data_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule